// File: doc/BRIEF.md
# Multi-Mode Program Bank Translator

This block turns a CPU address in the upper 40 KB of the address map into the upper address lines of a program ROM. Four bank registers, a mode/control register and an outer-bank register decide the layout: one 32 KB window, two 16 KB windows, or four 8 KB windows at $8000-$FFFF. An optional 8 KB ROM window at $6000-$7FFF takes its bank from bank register 3.

The CPU writes the registers through a plain write strobe with address and data. The same address bus drives the lookup. One clock after an address is presented, the block gives the 8 KB bank number, which is ROM address bits 20..13. In the same cycle it gives a select that tells the board to route $6000-$7FFF reads to ROM. The two upper bits of the bank number come from the outer-bank field, so the block can reach four 512 KB regions.

Top module: `prg_bank_xlate`

## Requirements
- R1: After reset every bank register holds all ones, and the mode, window-enable and outer fields are zero.
- R2: A write with A[15:12]=8 stores wr_data[5:0] in bank register A[1:0]. Writes to any other address leave the bank registers unchanged.
- R3: A write with A[15:12]=D and A[11:8] in 0..5 updates the control registers. Index A[1:0]=0 loads the mode from wr_data[2:0] and the window enable from wr_data[7]. Index 3 loads the outer bank from wr_data[2:1]. Index 1, index 2 and addresses from $D600 to $DFFF leave all of these fields unchanged.
- R4: In mode 0, $8000-$FFFF is a single 32 KB bank, number 15, so the 8 KB slots are 60..63.
- R5: In mode 1, $8000-$BFFF is 16 KB bank reg1[4:0] and $C000-$FFFF is 16 KB bank 31.
- R6: In modes 2 and 3, $8000, $A000 and $C000 are 8 KB banks reg0, reg1 and reg2, and $E000 is fixed to bank 63.
- R7: In mode 4, $8000-$FFFF is 32 KB bank reg3[3:0].
- R8: In mode 5, $8000-$BFFF is 16 KB bank reg1[4:0] and $C000-$FFFF is 16 KB bank reg3[4:0].
- R9: In modes 6 and 7, the four 8 KB slots take reg0, reg1, reg2 and reg3 in order.
- R10: The $6000 8 KB bank is (reg3*4+3) mod 64 in modes 0 and 4, (reg3*2+1) mod 64 in modes 1 and 5, and reg3 in the other modes.
- R11: rom_lo_sel is high only for an address in $6000-$7FFF while the window enable is set.
- R12: Output bits [7:6] equal the outer-bank field for every address at or above $6000, and bits [5:0] carry the inner 8 KB bank.
- R13: The outputs are registered and reflect the address of the previous clock. Addresses below $6000 give bank 0 and no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address, used both for register writes and for lookup |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| prg_bank | output | 8 | ROM address bits 20..13 (8 KB bank number) |
| rom_lo_sel | output | 1 | ROM selected for the $6000-$7FFF window |

## Verification
The assertions check several rules on every cycle. The window select never rises without the enable and a window address. The outer bits always follow the outer field. $E000 stays pinned to bank 63 in modes 2 and 3, and mode 0 always lands in the top 32 KB. Addresses below $6000 give zero. Writes outside the decoded ranges never disturb the registers. The scenarios cover the rest. They compare the full slot arithmetic of each mode and the shift-and-fill formulas of the $6000 window against a model. They also confirm that register index A[1:0] decodes correctly when higher address bits are set, and that the $D600 boundary rejects writes.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int DATA_W  = 8;
  localparam int INNER_W = 6;
  localparam int OUTER_W = 2;
  localparam int NREG    = 4;
  localparam int IDX_W   = $clog2(NREG);
  localparam int BANK_W  = INNER_W + OUTER_W;

  typedef logic [INNER_W-1:0] inner_t;

  typedef enum logic [2:0] {
    M_FIX32 = 3'd0, M_SW16F = 3'd1, M_SW8F = 3'd2, M_SW8F_B = 3'd3,
    M_SW32  = 3'd4, M_SW16  = 3'd5, M_SW8  = 3'd6, M_SW8_B  = 3'd7
  } prg_mode_e;
endpackage

// File: rtl/prg_reg_file.sv
module prg_reg_file
  import prg_map_pkg::*;
#(
  parameter int N_BANK = NREG,
  parameter int IW     = INNER_W,
  parameter int OW     = OUTER_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [15:0]            addr,
  input  logic                   wr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [N_BANK-1:0][IW-1:0] bank_q,
  output prg_mode_e              mode_q,
  output logic                   win_en_q,
  output logic [OW-1:0]          outer_q
);
  localparam int IXW = $clog2(N_BANK);

  logic bank_hit, ctrl_hit;
  logic [IXW-1:0] idx;
  logic unused_addr_bits;

  assign idx      = addr[IXW-1:0];
  assign bank_hit = wr && (addr[15:12] == 4'h8);
  assign ctrl_hit = wr && (addr[15:12] == 4'hD) && (addr[11:8] <= 4'h5);
  assign unused_addr_bits = ^{addr[7:2], wdata[6]};

  genvar gi;
  generate
    for (gi = 0; gi < N_BANK; gi++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst)
          bank_q[gi] <= '1;
        else if (bank_hit && (idx == IXW'(gi)))
          bank_q[gi] <= wdata[IW-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_FIX32;
      win_en_q <= 1'b0;
      outer_q  <= '0;
    end else if (ctrl_hit) begin
      if (addr[1:0] == 2'd0) begin
        mode_q   <= prg_mode_e'(wdata[2:0]);
        win_en_q <= wdata[7];
      end
      if (addr[1:0] == 2'd3)
        outer_q <= wdata[OW:1];
    end
  end

  // R1: reset state
  p_reset_values_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (bank_q == '1) && (mode_q == M_FIX32) && !win_en_q && (outer_q == '0));

  // R2/R3: writes outside decoded ranges change nothing
  p_ignored_write_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(wr) && !($past(addr[15:12]) == 4'h8) && !($past(addr[15:12]) == 4'hD)
    |-> $stable(bank_q) && $stable(mode_q) && $stable(win_en_q) && $stable(outer_q));

  p_ctrl_range_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(wr) && ($past(addr[15:12]) == 4'hD) && ($past(addr[11:8]) > 4'h5)
    |-> $stable(mode_q) && $stable(win_en_q) && $stable(outer_q));
endmodule

// File: rtl/prg_slot_mapper.sv
module prg_slot_mapper
  import prg_map_pkg::*;
#(
  parameter int N_BANK = NREG,
  parameter int IW     = INNER_W
) (
  input  logic [2:0]                page,
  input  logic [N_BANK-1:0][IW-1:0] bank_q,
  input  prg_mode_e                 mode,
  output logic [IW-1:0]             inner,
  output logic                      in_window,
  output logic                      in_upper
);
  logic [1:0]    slot;
  logic [IW-1:0] r0, r1, r2, r3;
  logic [IW-1:0] win_bank, up_bank;

  assign slot      = page[1:0];
  assign in_window = (page == 3'b011);
  assign in_upper  = page[2];
  assign r0 = bank_q[0];
  assign r1 = bank_q[1];
  assign r2 = bank_q[2];
  assign r3 = bank_q[3];

  // $6000 window: shift-and-fill from register 3
  always_comb begin
    unique case (mode)
      M_FIX32, M_SW32: win_bank = {r3[IW-3:0], 2'b11};
      M_SW16F, M_SW16: win_bank = {r3[IW-2:0], 1'b1};
      default:         win_bank = r3;
    endcase
  end

  // $8000-$FFFF slot arithmetic
  always_comb begin
    unique case (mode)
      M_FIX32: up_bank = {{(IW-2){1'b1}} & {{(IW-6){1'b0}}, 4'hF}, slot};
      M_SW32:  up_bank = {r3[IW-3:0], slot};
      M_SW16F: up_bank = slot[1] ? {{(IW-1){1'b1}}, slot[0]} : {r1[IW-2:0], slot[0]};
      M_SW16:  up_bank = slot[1] ? {r3[IW-2:0], slot[0]}    : {r1[IW-2:0], slot[0]};
      M_SW8F, M_SW8F_B: begin
        unique case (slot)
          2'd0: up_bank = r0;
          2'd1: up_bank = r1;
          2'd2: up_bank = r2;
          default: up_bank = '1;
        endcase
      end
      default: begin
        unique case (slot)
          2'd0: up_bank = r0;
          2'd1: up_bank = r1;
          2'd2: up_bank = r2;
          default: up_bank = r3;
        endcase
      end
    endcase
  end

  always_comb begin
    if (in_upper)       inner = up_bank;
    else if (in_window) inner = win_bank;
    else                inner = '0;
  end
endmodule

// File: rtl/prg_bank_xlate.sv
module prg_bank_xlate
  import prg_map_pkg::*;
#(
  parameter int N_BANK = NREG,
  parameter int IW     = INNER_W,
  parameter int OW     = OUTER_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [IW+OW-1:0]  prg_bank,
  output logic              rom_lo_sel
);
  logic [N_BANK-1:0][IW-1:0] bank_q;
  prg_mode_e                 mode_q;
  logic                      win_en_q;
  logic [OW-1:0]             outer_q;
  logic [IW-1:0]             inner;
  logic                      in_window, in_upper;

  prg_reg_file #(.N_BANK(N_BANK), .IW(IW), .OW(OW)) u_regs (
    .clk(clk), .rst(rst), .addr(cpu_addr), .wr(cpu_wr), .wdata(cpu_wdata),
    .bank_q(bank_q), .mode_q(mode_q), .win_en_q(win_en_q), .outer_q(outer_q)
  );

  prg_slot_mapper #(.N_BANK(N_BANK), .IW(IW)) u_map (
    .page(cpu_addr[15:13]), .bank_q(bank_q), .mode(mode_q),
    .inner(inner), .in_window(in_window), .in_upper(in_upper)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_bank   <= '0;
      rom_lo_sel <= 1'b0;
    end else begin
      prg_bank   <= (in_upper || in_window) ? {outer_q, inner} : '0;
      rom_lo_sel <= in_window && win_en_q;
    end
  end

  p_win_gate_r11: assert property (@(posedge clk) disable iff (rst)
    rom_lo_sel |-> $past(win_en_q) && ($past(cpu_addr[15:13]) == 3'b011));

  p_last_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(mode_q) inside {M_SW8F, M_SW8F_B}) && ($past(cpu_addr[15:13]) == 3'b111)
    |-> prg_bank[IW-1:0] == '1);

  p_outer_bits_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(cpu_addr[15:13]) >= 3'b011) |-> prg_bank[IW+OW-1:IW] == $past(outer_q));

  p_fixed32_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(mode_q) == M_FIX32) && $past(cpu_addr[15]) |-> prg_bank[IW-1:2] == 4'hF);

  p_low_zero_r13: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(cpu_addr[15:13]) < 3'b011) |-> (prg_bank == '0) && !rom_lo_sel);
endmodule

// File: tb/prg_bank_xlate_tb_top.sv
module prg_bank_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  prg_bank;
  logic        rom_lo_sel;

  always #2.5 clk = ~clk;

  prg_bank_xlate dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .prg_bank(prg_bank), .rom_lo_sel(rom_lo_sel)
  );

  typedef struct {
    logic [7:0] bank;
    logic       sel;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  logic lookup_v = 1'b0;
  logic lv_q     = 1'b0;
  bit   done     = 1'b0;

  // shadow state, updated by the write task from the requirements
  int sb[4];
  int sc_mode, sc_win, sc_outer;

  function automatic int model_bank(int a);
    int m, inner, s, r3;
    m = sc_mode; r3 = sb[3];
    if (a < 'h6000) return 0;
    if (a < 'h8000) begin
      if (m == 0 || m == 4)      inner = ((r3 << 2) + 3) & 63;
      else if (m == 1 || m == 5) inner = ((r3 << 1) + 1) & 63;
      else                       inner = r3 & 63;
    end else begin
      s = (a >> 13) & 3;
      case (m)
        0: inner = 15 * 4 + s;
        4: inner = (r3 & 15) * 4 + s;
        1: inner = (s < 2) ? ((sb[1] & 31) * 2 + (s & 1)) : (31 * 2 + (s & 1));
        5: inner = (s < 2) ? ((sb[1] & 31) * 2 + (s & 1)) : ((r3 & 31) * 2 + (s & 1));
        2, 3: inner = (s == 3) ? 63 : (sb[s] & 63);
        default: inner = sb[s] & 63;
      endcase
    end
    return sc_outer * 64 + inner;
  endfunction

  task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a[15:12] == 4'h8) sb[a[1:0]] = d & 63;
    if (a[15:12] == 4'hD && a[11:8] <= 4'h5) begin
      if (a[1:0] == 2'd0) begin sc_mode = d & 7; sc_win = d[7]; end
      if (a[1:0] == 2'd3) sc_outer = (d >> 1) & 3;
    end
  endtask

  task automatic lookup(input logic [15:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_addr = a; lookup_v = 1'b1;
    e.bank = 8'(model_bank(int'(a)));
    e.sel  = (a >= 16'h6000 && a < 16'h8000) && (sc_win != 0);
    e.tag  = tag;
    exp_q.push_back(e);
    @(negedge clk);
    lookup_v = 1'b0;
  endtask

  always @(posedge clk) lv_q <= lookup_v;

  // monitor: compares registered outputs one cycle after each lookup
  always @(negedge clk) begin
    if (lv_q) begin
      exp_t e;
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R13: output with no expected item, actual bank=%02h expected none", prg_bank);
      end else begin
        e = exp_q.pop_front();
        if (prg_bank !== e.bank || rom_lo_sel !== e.sel) begin
          n_fail++;
          $display("FAIL %s: actual bank=%02h sel=%0b expected bank=%02h sel=%0b",
                   e.tag, prg_bank, rom_lo_sel, e.bank, e.sel);
        end
      end
    end
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) sb[i] = 63;
    sc_mode = 0; sc_win = 0; sc_outer = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R4 reset state, R13 low addresses
    n_checks++;
    if (prg_bank !== 8'h00 || rom_lo_sel !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual bank=%02h sel=%0b expected bank=00 sel=0", prg_bank, rom_lo_sel);
    end
    lookup(16'h8000, "R1 R4 reset slot0");
    lookup(16'hA123, "R1 R4 reset slot1");
    lookup(16'hFFFF, "R1 R4 reset slot3");
    lookup(16'h6000, "R1 R11 reset window off");
    lookup(16'h5000, "R13 below window");

    // R2 bank register loads, decode of index with higher address bits
    reg_write(16'h8000, 8'h05);
    reg_write(16'h8001, 8'h12);
    reg_write(16'h8FF2, 8'h2A);
    reg_write(16'h8FF3, 8'h07);
    reg_write(16'h9000, 8'h00);   // R2 ignored
    reg_write(16'hE000, 8'h00);   // R2 ignored
    reg_write(16'hD003, 8'h04);   // R12 outer = 2

    for (int m = 0; m < 8; m++) begin
      string mt;
      case (m)
        0: mt = "R4"; 1: mt = "R5"; 2, 3: mt = "R6"; 4: mt = "R7";
        5: mt = "R8"; default: mt = "R9";
      endcase
      reg_write(16'hD000, 8'(8'h80 | m));
      lookup(16'h6ABC, $sformatf("R10 R11 R12 window mode %0d", m));
      lookup(16'h8000, $sformatf("%s R2 R12 slot0 mode %0d", mt, m));
      lookup(16'hA000, $sformatf("%s R2 slot1 mode %0d", mt, m));
      lookup(16'hC000, $sformatf("%s slot2 mode %0d", mt, m));
      lookup(16'hE000, $sformatf("%s slot3 mode %0d", mt, m));
    end

    // R3: $D600 and index 1/2 writes ignored; mode stays 7
    reg_write(16'hD600, 8'h01);
    reg_write(16'hD001, 8'h00);
    reg_write(16'hD502, 8'h00);
    lookup(16'hE000, "R3 write above D5FF ignored");
    lookup(16'h7FFF, "R3 R11 window still enabled");

    // R11: enable clear drops the select
    reg_write(16'hD000, 8'h06);
    lookup(16'h6000, "R11 enable clear");
    lookup(16'h8000, "R9 after enable clear");

    // R3 / R12: outer via last decoded page, R2 index wrap
    reg_write(16'hD503, 8'h02);
    reg_write(16'h8004, 8'h3B);
    lookup(16'h8000, "R2 R12 index wrap outer 1");
    reg_write(16'hD000, 8'h81);
    lookup(16'h7000, "R10 mode1 window");
    lookup(16'hC000, "R5 fixed upper half");
    lookup(16'h0000, "R13 zero page");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R13: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule